// File: doc/BRIEF.md
# Next-Line Fetch Predictor

This block sits beside the instruction cache and picks, in the same cycle as a fetch, the cache index and way that the front end should read next. It keeps one small entry per cache fetch line: a predicted next index, a predicted way and one hysteresis bit. The front end can therefore issue a new fetch every cycle without waiting for the full branch predictor to produce its answer.

One cycle after a fetch, the branch predictor supplies its own next index and way for that fetch. If the two disagree, the branch predictor's answer is used. The block raises `bubble` for one cycle, drops the fetch that went out on the wrong guess and steers the next fetch to the corrected line. When the branch predictor marks the fetch as a memory-format call or a jump, the line prediction stands, and there is no compare and no training. An entry is rewritten only after two mismatches in a row. A line fill resets the entry to point at the following sequential line. Jumps through a register train an entry directly. A flush from the back end overrides everything.

Top module: `line_pred_top`

## Requirements
- R1: After reset, every entry predicts index (i+1) modulo the table depth with way 0 and a clear hysteresis bit, and `bubble` is low.
- R2: With no flush and no override, `next_idx` and `next_way` show in the same cycle the entry stored for `fetch_idx`.
- R3: A fill of line i makes entry i predict index (i+1) modulo depth with way 0 and clears its hysteresis bit. The change is visible from the next cycle.
- R4: In the cycle after a valid fetch, if `bp_valid` is high, `bp_keep_line` is low and {`bp_idx`,`bp_way`} differs from the prediction given for that fetch, then `bubble` is high and `next_idx`/`next_way` equal `bp_idx`/`bp_way`.
- R5: When `bp_keep_line` is high, the line prediction stands: no bubble and no training.
- R6: On a compared fetch, a mismatch while the hysteresis bit is clear sets the bit and leaves the prediction unchanged. A mismatch while the bit is set replaces the prediction with the branch predictor's index and way and clears the bit. A match clears the bit.
- R7: A register-jump training writes the jump target index and way into the entry of the source line and clears its hysteresis bit. The change is visible from the next cycle.
- R8: `flush_valid` forces `next_idx`/`next_way` to `flush_idx`/`flush_way` above both predictions, and the fetch issued in that cycle is never compared.
- R9: A fetch issued in a cycle where `bubble` is high is dropped and is never compared one cycle later.
- R10: At most one table write happens per cycle. The priority is fill, then register-jump training, then branch-predictor training, and the lower writes are lost.
- R11: `bp_valid` without a live fetch in the compare stage has no effect: no bubble and no training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch is issued this cycle |
| fetch_idx | input | IDX_W | Cache index being fetched |
| fill_valid | input | 1 | A cache line fill completes |
| fill_idx | input | IDX_W | Index of the filled line |
| jump_valid | input | 1 | Register-jump training request |
| jump_src_idx | input | IDX_W | Line holding the jump |
| jump_tgt_idx | input | IDX_W | Resolved target index |
| jump_tgt_way | input | WAY_W | Resolved target way |
| bp_valid | input | 1 | Branch predictor result for the previous fetch |
| bp_keep_line | input | 1 | Fetch was a memory-format call or jump; keep the line prediction |
| bp_idx | input | IDX_W | Branch predictor next index |
| bp_way | input | WAY_W | Branch predictor next way |
| flush_valid | input | 1 | Back-end redirect |
| flush_idx | input | IDX_W | Redirect index |
| flush_way | input | WAY_W | Redirect way |
| next_idx | output | IDX_W | Index to fetch next |
| next_way | output | WAY_W | Way to fetch next |
| bubble | output | 1 | Override: the current fetch is dropped |

## Verification
The assertions assume that every input is a known value once reset is released, and that a table write is judged only by the index captured in the cycle of the write. The bench drives every input from a single process just after the falling edge, so all inputs are defined and stable across each rising edge. It pairs `bp_valid` with the fetch held in its own model. This lets it choose on purpose between matching and mismatching answers, and it also sends some `bp_valid` pulses when no fetch is pending. Directed sequences cover the hysteresis pairs, collisions of simultaneous writes on one line, a flush during an override, and index wrap at the top of the table. A seeded random phase then mixes all of these.

// File: rtl/lp_pkg.sv
`timescale 1ns/1ps
package lp_pkg;
  typedef enum logic [1:0] {WR_NONE, WR_FILL, WR_JUMP, WR_TRAIN} lp_wr_e;

  // new hysteresis bit after a compare
  function automatic logic hyst_after(input logic mism, input logic hyst);
    return mism & ~hyst;
  endfunction

  // whether a compare replaces the stored target
  function automatic logic take_bp(input logic mism, input logic hyst);
    return mism & hyst;
  endfunction
endpackage

// File: rtl/lp_table.sv
`timescale 1ns/1ps
module lp_table import lp_pkg::*; #(
  parameter int IDX_W = 6,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] rd_nidx,
  output logic [WAY_W-1:0] rd_way,
  input  logic [IDX_W-1:0] chk_idx,
  output logic [IDX_W-1:0] chk_nidx,
  output logic [WAY_W-1:0] chk_way,
  output logic             chk_hyst,
  input  logic             fill_v,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             jmp_v,
  input  logic [IDX_W-1:0] jmp_src,
  input  logic [IDX_W-1:0] jmp_idx,
  input  logic [WAY_W-1:0] jmp_way,
  input  logic             trn_v,
  input  logic [IDX_W-1:0] trn_src,
  input  logic [IDX_W-1:0] trn_idx,
  input  logic [WAY_W-1:0] trn_way,
  input  logic             trn_hyst,
  output lp_wr_e           wr_src
);
  localparam int DEPTH = 1 << IDX_W;

  function automatic logic [IDX_W-1:0] seq_next(input logic [IDX_W-1:0] i);
    return i + IDX_W'(1);
  endfunction

  logic [IDX_W-1:0] nidx_q [DEPTH];
  logic [WAY_W-1:0] way_q  [DEPTH];
  logic             hyst_q [DEPTH];

  logic [IDX_W-1:0] wr_at, wr_nidx;
  logic [WAY_W-1:0] wr_way;
  logic             wr_hyst;

  always_comb begin
    wr_src  = WR_NONE;
    wr_at   = trn_src;
    wr_nidx = trn_idx;
    wr_way  = trn_way;
    wr_hyst = trn_hyst;
    if (fill_v) begin
      wr_src  = WR_FILL;
      wr_at   = fill_idx;
      wr_nidx = seq_next(fill_idx);
      wr_way  = '0;
      wr_hyst = 1'b0;
    end else if (jmp_v) begin
      wr_src  = WR_JUMP;
      wr_at   = jmp_src;
      wr_nidx = jmp_idx;
      wr_way  = jmp_way;
      wr_hyst = 1'b0;
    end else if (trn_v) begin
      wr_src  = WR_TRAIN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        nidx_q[i] <= seq_next(IDX_W'(i));
        way_q[i]  <= '0;
        hyst_q[i] <= 1'b0;
      end
    end else if (wr_src != WR_NONE) begin
      nidx_q[wr_at] <= wr_nidx;
      way_q[wr_at]  <= wr_way;
      hyst_q[wr_at] <= wr_hyst;
    end
  end

  assign rd_nidx  = nidx_q[rd_idx];
  assign rd_way   = way_q[rd_idx];
  assign chk_nidx = nidx_q[chk_idx];
  assign chk_way  = way_q[chk_idx];
  assign chk_hyst = hyst_q[chk_idx];

  // R3: a fill leaves the line pointing at its sequential successor
  p_fill_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_v |=> (nidx_q[$past(fill_idx)] == $past(fill_idx) + IDX_W'(1))
               && !hyst_q[$past(fill_idx)]);

  // R10: a jump without a fill lands in the table
  p_jump_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_v && !fill_v) |=> (way_q[$past(jmp_src)] == $past(jmp_way))
                           && (nidx_q[$past(jmp_src)] == $past(jmp_idx)));
endmodule

// File: rtl/lp_check.sv
`timescale 1ns/1ps
module lp_check import lp_pkg::*; #(
  parameter int IDX_W = 6,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_v,
  input  logic [IDX_W-1:0] fetch_idx,
  input  logic [IDX_W-1:0] pred_idx,
  input  logic [WAY_W-1:0] pred_way,
  input  logic             flush_v,
  input  logic             bp_v,
  input  logic             bp_keep,
  input  logic [IDX_W-1:0] bp_idx,
  input  logic [WAY_W-1:0] bp_way,
  input  logic [IDX_W-1:0] cur_nidx,
  input  logic [WAY_W-1:0] cur_way,
  input  logic             cur_hyst,
  output logic [IDX_W-1:0] s1_src,
  output logic             ovr,
  output logic             trn_v,
  output logic [IDX_W-1:0] trn_idx,
  output logic [WAY_W-1:0] trn_way,
  output logic             trn_hyst
);
  logic             s1_v;
  logic [IDX_W-1:0] s1_pidx;
  logic [WAY_W-1:0] s1_pway;
  logic             cmp_v, mism;

  assign cmp_v = s1_v & bp_v & ~bp_keep;
  assign mism  = cmp_v & ((bp_idx != s1_pidx) | (bp_way != s1_pway));
  assign ovr   = mism;

  assign trn_v    = cmp_v & (mism | cur_hyst);
  assign trn_idx  = take_bp(mism, cur_hyst) ? bp_idx : cur_nidx;
  assign trn_way  = take_bp(mism, cur_hyst) ? bp_way : cur_way;
  assign trn_hyst = hyst_after(mism, cur_hyst);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_src  <= '0;
      s1_pidx <= '0;
      s1_pway <= '0;
    end else begin
      s1_v    <= fetch_v & ~flush_v & ~mism;
      s1_src  <= fetch_idx;
      s1_pidx <= pred_idx;
      s1_pway <= pred_way;
    end
  end

  // R9: the fetch issued under an override is never compared
  p_ovr_squash_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> !s1_v);

  // R8: the fetch issued under a flush is never compared
  p_flush_squash_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_v |=> !s1_v);

  // R5: a kept line prediction neither bubbles nor trains
  p_keep_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_v && bp_keep) |-> !ovr && !trn_v);

  // R11: no live fetch, no override
  p_idle_bp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_v && !s1_v) |-> !ovr && !trn_v);
endmodule

// File: rtl/line_pred_top.sv
`timescale 1ns/1ps
module line_pred_top import lp_pkg::*; #(
  parameter int IDX_W = 6,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [IDX_W-1:0] fetch_idx,
  input  logic             fill_valid,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             jump_valid,
  input  logic [IDX_W-1:0] jump_src_idx,
  input  logic [IDX_W-1:0] jump_tgt_idx,
  input  logic [WAY_W-1:0] jump_tgt_way,
  input  logic             bp_valid,
  input  logic             bp_keep_line,
  input  logic [IDX_W-1:0] bp_idx,
  input  logic [WAY_W-1:0] bp_way,
  input  logic             flush_valid,
  input  logic [IDX_W-1:0] flush_idx,
  input  logic [WAY_W-1:0] flush_way,
  output logic [IDX_W-1:0] next_idx,
  output logic [WAY_W-1:0] next_way,
  output logic             bubble
);
  logic [IDX_W-1:0] pred_idx, cur_nidx, s1_src, trn_idx;
  logic [WAY_W-1:0] pred_way, cur_way, trn_way;
  logic             cur_hyst, ovr, trn_v, trn_hyst;
  lp_wr_e           wr_src;

  lp_table #(.IDX_W(IDX_W), .WAY_W(WAY_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(fetch_idx), .rd_nidx(pred_idx), .rd_way(pred_way),
    .chk_idx(s1_src), .chk_nidx(cur_nidx), .chk_way(cur_way), .chk_hyst(cur_hyst),
    .fill_v(fill_valid), .fill_idx(fill_idx),
    .jmp_v(jump_valid), .jmp_src(jump_src_idx), .jmp_idx(jump_tgt_idx), .jmp_way(jump_tgt_way),
    .trn_v(trn_v), .trn_src(s1_src), .trn_idx(trn_idx), .trn_way(trn_way), .trn_hyst(trn_hyst),
    .wr_src(wr_src)
  );

  lp_check #(.IDX_W(IDX_W), .WAY_W(WAY_W)) u_check (
    .clk(clk), .rst_n(rst_n),
    .fetch_v(fetch_valid), .fetch_idx(fetch_idx),
    .pred_idx(pred_idx), .pred_way(pred_way),
    .flush_v(flush_valid),
    .bp_v(bp_valid), .bp_keep(bp_keep_line), .bp_idx(bp_idx), .bp_way(bp_way),
    .cur_nidx(cur_nidx), .cur_way(cur_way), .cur_hyst(cur_hyst),
    .s1_src(s1_src), .ovr(ovr),
    .trn_v(trn_v), .trn_idx(trn_idx), .trn_way(trn_way), .trn_hyst(trn_hyst)
  );

  always_comb begin
    if (flush_valid) begin
      next_idx = flush_idx;
      next_way = flush_way;
    end else if (ovr) begin
      next_idx = bp_idx;
      next_way = bp_way;
    end else begin
      next_idx = pred_idx;
      next_way = pred_way;
    end
  end
  assign bubble = ovr;

  // R8: a flush owns the next fetch
  p_flush_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (next_idx == flush_idx) && (next_way == flush_way));

  // R4: a bubble redirects to the branch predictor's line
  p_bubble_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bubble && !flush_valid) |-> (next_idx == bp_idx) && (next_way == bp_way));

  // R10: branch training loses to a fill or jump in the same cycle
  p_train_loses_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trn_v && (fill_valid || jump_valid)) |-> (wr_src != WR_TRAIN));
endmodule

// File: tb/test_line_pred_top.sv
`timescale 1ns/1ps
module test_line_pred_top;
  localparam int IDX_W = 6;
  localparam int WAY_W = 1;
  localparam int DEPTH = 1 << IDX_W;
  localparam int WMAX  = 1 << WAY_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 0, fill_valid = 0, jump_valid = 0, bp_valid = 0, bp_keep_line = 0, flush_valid = 0;
  logic [IDX_W-1:0] fetch_idx = '0, fill_idx = '0, jump_src_idx = '0, jump_tgt_idx = '0, bp_idx = '0, flush_idx = '0;
  logic [WAY_W-1:0] jump_tgt_way = '0, bp_way = '0, flush_way = '0;
  logic [IDX_W-1:0] next_idx;
  logic [WAY_W-1:0] next_way;
  logic             bubble;

  always #10 clk = ~clk;

  line_pred_top #(.IDX_W(IDX_W), .WAY_W(WAY_W)) i_line_pred_top (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_idx(fetch_idx),
    .fill_valid(fill_valid), .fill_idx(fill_idx),
    .jump_valid(jump_valid), .jump_src_idx(jump_src_idx),
    .jump_tgt_idx(jump_tgt_idx), .jump_tgt_way(jump_tgt_way),
    .bp_valid(bp_valid), .bp_keep_line(bp_keep_line), .bp_idx(bp_idx), .bp_way(bp_way),
    .flush_valid(flush_valid), .flush_idx(flush_idx), .flush_way(flush_way),
    .next_idx(next_idx), .next_way(next_way), .bubble(bubble)
  );

  // behavioural reference
  int m_tgt [DEPTH];
  int m_way [DEPTH];
  bit m_hys [DEPTH];
  bit m_live;
  int m_src, m_pt, m_pw;

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";

  function automatic bit diverges();
    return m_live && bp_valid && !bp_keep_line &&
           (int'(bp_idx) != m_pt || int'(bp_way) != m_pw);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin
      m_tgt[i] = (i + 1) % DEPTH; m_way[i] = 0; m_hys[i] = 0;
    end
    m_live = 0; m_src = 0; m_pt = 0; m_pw = 0;
  endtask

  task automatic compare();
    int ei, ew; bit eb;
    eb = diverges();
    if (flush_valid) begin ei = flush_idx; ew = flush_way; end
    else if (eb) begin ei = bp_idx; ew = bp_way; end
    else begin ei = m_tgt[fetch_idx]; ew = m_way[fetch_idx]; end
    n_cmp++;
    if (int'(next_idx) != ei || int'(next_way) != ew || bubble != eb) begin
      n_bad++;
      $display("FAIL %s: next_idx=%0d next_way=%0d bubble=%0b expected %0d %0d %0b",
               tag, next_idx, next_way, bubble, ei, ew, eb);
    end
  endtask

  task automatic model_step();
    bit mis, cmp;
    int ft, fw;
    mis = diverges();
    cmp = m_live && bp_valid && !bp_keep_line;
    ft = m_tgt[fetch_idx]; fw = m_way[fetch_idx];
    if (fill_valid) begin
      m_tgt[fill_idx] = (int'(fill_idx) + 1) % DEPTH; m_way[fill_idx] = 0; m_hys[fill_idx] = 0;
    end else if (jump_valid) begin
      m_tgt[jump_src_idx] = jump_tgt_idx; m_way[jump_src_idx] = jump_tgt_way; m_hys[jump_src_idx] = 0;
    end else if (cmp) begin
      if (mis && m_hys[m_src]) begin
        m_tgt[m_src] = bp_idx; m_way[m_src] = bp_way; m_hys[m_src] = 0;
      end else if (mis) m_hys[m_src] = 1;
      else m_hys[m_src] = 0;
    end
    m_live = fetch_valid && !flush_valid && !mis;
    m_src = fetch_idx; m_pt = ft; m_pw = fw;
  endtask

  // inputs set just after negedge; check at +5; model updates at posedge
  task automatic tick();
    #5;
    compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
    fetch_valid = 0; fill_valid = 0; jump_valid = 0; bp_valid = 0;
    bp_keep_line = 0; flush_valid = 0;
  endtask

  task automatic fetch(input int idx);
    fetch_valid = 1; fetch_idx = IDX_W'(idx);
  endtask

  task automatic bp(input int idx, input int way);
    bp_valid = 1; bp_idx = IDX_W'(idx); bp_way = WAY_W'(way);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    tag = "R1"; // sequential reset contents, including wrap at the top line
    for (int i = 0; i < DEPTH; i++) begin fetch(i); tick(); end

    tag = "R2";
    fetch(DEPTH - 1); tick();
    fetch(7); tick();

    tag = "R3"; // fill after a jump retrained the line
    jump_valid = 1; jump_src_idx = 10; jump_tgt_idx = 40; jump_tgt_way = 1; tick();
    fetch(10); tick();
    fill_valid = 1; fill_idx = 10; tick();
    fetch(10); tick();
    fill_valid = 1; fill_idx = DEPTH - 1; tick();
    fetch(DEPTH - 1); tick();

    tag = "R4"; // first mismatch: bubble, entry kept
    fetch(5); tick();
    bp(30, 1); tick();
    tag = "R6";
    fetch(5); tick();
    bp(30, 1); tick();          // second in a row: rewrite
    fetch(5); tick();           // now predicts 30/1
    bp(30, 1); tick();          // match
    fetch(5); tick();
    bp(12, 0); tick();          // one miss sets hysteresis
    fetch(5); tick();
    bp(30, 1); tick();          // match clears it
    fetch(5); tick();
    bp(12, 0); tick();          // single miss again: no rewrite
    fetch(5); tick();

    tag = "R5";
    fetch(20); tick();
    bp(50, 1); bp_keep_line = 1; tick();
    fetch(20); tick();
    bp(50, 1); bp_keep_line = 1; tick();
    fetch(20); tick();

    tag = "R7";
    jump_valid = 1; jump_src_idx = 33; jump_tgt_idx = 3; jump_tgt_way = 1; tick();
    fetch(33); tick();

    tag = "R8";
    fetch(8); tick();
    bp(60, 1); flush_valid = 1; flush_idx = 17; flush_way = 1; fetch(2); tick();
    bp(61, 0); fetch(3); tick(); // fetch 2 was flushed: no compare

    tag = "R9";
    fetch(9); tick();
    bp(44, 1); fetch(11); tick(); // override; fetch 11 dropped
    bp(45, 0); tick();            // no compare, no bubble

    tag = "R10";
    fetch(14); tick();
    bp(1, 1); fill_valid = 1; fill_idx = 14;
    jump_valid = 1; jump_src_idx = 14; jump_tgt_idx = 2; jump_tgt_way = 1; tick();
    fetch(14); tick();
    fetch(15); tick();
    bp(1, 1); jump_valid = 1; jump_src_idx = 15; jump_tgt_idx = 2; jump_tgt_way = 1; tick();
    fetch(15); tick();

    tag = "R11";
    bp(63, 1); tick();
    bp(62, 0); fetch(4); tick();

    tag = "R2"; // mixed traffic
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 9) < 8) fetch($urandom_range(0, DEPTH - 1));
      if (m_live && $urandom_range(0, 9) < 8) begin
        if ($urandom_range(0, 2) == 0) bp($urandom_range(0, DEPTH - 1), $urandom_range(0, WMAX - 1));
        else bp(m_pt, m_pw);
        bp_keep_line = ($urandom_range(0, 9) == 0);
      end else if ($urandom_range(0, 19) == 0) bp($urandom_range(0, DEPTH - 1), 0);
      if ($urandom_range(0, 19) == 0) begin fill_valid = 1; fill_idx = IDX_W'($urandom_range(0, DEPTH - 1)); end
      if ($urandom_range(0, 19) == 0) begin
        jump_valid = 1; jump_src_idx = IDX_W'($urandom_range(0, DEPTH - 1));
        jump_tgt_idx = IDX_W'($urandom_range(0, DEPTH - 1)); jump_tgt_way = WAY_W'($urandom_range(0, WMAX - 1));
      end
      if ($urandom_range(0, 29) == 0) begin
        flush_valid = 1; flush_idx = IDX_W'($urandom_range(0, DEPTH - 1)); flush_way = WAY_W'($urandom_range(0, WMAX - 1));
      end
      tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 50000);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule